// File: doc/BRIEF.md
# Load-Use Interlock and Early Branch Redirect Unit

This block is the hazard controller of a five-stage in-order pipeline that settles conditional branches in the decode stage. It owns the program counter and the fetch/decode pipeline register. Each cycle it decides three things: whether the instruction in decode must wait, whether the instruction in fetch must be thrown away, and what address fetch uses next.

The wait condition is a load-use interlock. When the instruction in execute is a load, and its destination register number matches either source register number of the instruction in decode, the unit freezes the PC and the fetch/decode register for one cycle. It also raises a bubble request, which tells the decode stage to pass an all-zero control word into the decode/execute register.

The redirect condition is an equal-compare branch. Branches are assumed not taken, so the instruction after a branch is always fetched. The two register operand values are compared in decode. If they are equal, the wrong-path instruction is squashed into a zero word and the PC jumps to the branch target. The decode, execute and register-file logic sit outside the block and connect to it through plain control pins. There is no streaming data path, so no valid/ready handshake is involved.

Top module: `hzu_top`

## Requirements
- R1: While rst_n is low, pc reads 0, id_instr reads 0 and id_pc4 reads 0.
- R2: With no stall and no redirect, each rising clock edge sets pc to pc+4, loads id_instr with fetch_instr and loads id_pc4 with the old pc+4.
- R3: bubble is 1 in the same cycle when ex_is_load is 1 and ex_load_dst equals id_instr[25:21] or id_instr[20:16].
- R4: bubble stays 0 when ex_is_load is 0, or when ex_load_dst matches neither source field. Only the instruction directly behind the load is checked.
- R5: pc_en and id_en are active high and both read the inverse of bubble. While they are 0, the next edge leaves pc, id_instr and id_pc4 unchanged.
- R6: An instruction with opcode id_instr[31:26] = 6'b000100 is an equal-compare branch. When rs_val equals rt_val and there is no stall, if_flush is 1 and the next edge loads pc with br_target. Any other opcode never raises if_flush.
- R7: br_target equals id_pc4 plus the sign-extended id_instr[15:0] shifted left by 2. Negative offsets give backward targets.
- R8: The edge at which if_flush is 1 loads id_instr with 0, which is a no-op.
- R9: A branch whose operands differ raises no flush, and the pipeline advances as in R2.
- R10: When a stall and a taken branch fall in the same cycle, the stall wins: if_flush is 0 and pc is held. The branch is evaluated again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_instr | input | 32 | Instruction word read at the current pc |
| rs_val | input | 32 | Register-file value for the decode instruction's first source |
| rt_val | input | 32 | Register-file value for the decode instruction's second source |
| ex_is_load | input | 1 | The instruction in execute reads data memory |
| ex_load_dst | input | 5 | Destination register number of the instruction in execute |
| pc | output | 32 | Current fetch address |
| id_instr | output | 32 | Instruction held in the fetch/decode register |
| id_pc4 | output | 32 | Address following id_instr |
| pc_en | output | 1 | PC write enable |
| id_en | output | 1 | Fetch/decode register write enable |
| bubble | output | 1 | Request to zero the control word entering decode/execute |
| if_flush | output | 1 | Squash the instruction in fetch |
| br_target | output | 32 | Computed branch destination |

## Verification
The two functions that can land in the same cycle are the load-use interlock and the branch redirect. They collide when a taken branch sits in decode directly behind a load that writes one of the branch's source registers. The bench sets up exactly that case: the branch is placed in decode, its operand values are made equal, and ex_load_dst is driven to match the branch's second source field. It then checks three things across two cycles. In the first cycle bubble must be high, if_flush low, and pc and id_instr must hold. In the next cycle, with the load gone, the same branch must flush and redirect to its target.

// File: rtl/hzu_pkg.sv
package hzu_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned REG_W = 5;
  localparam int unsigned OPC_W = 6;
  localparam int unsigned IMM_W = 16;
  localparam logic [OPC_W-1:0] OPC_BR_EQ = 6'b000100;
  localparam int unsigned OPC_LSB = 26;
  localparam int unsigned SRC_A_LSB = 21;
  localparam int unsigned SRC_B_LSB = 16;
endpackage

// File: rtl/hzu_loaduse.sv
module hzu_loaduse #(
  parameter int unsigned REG_W = hzu_pkg::REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] ex_load_dst,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  output logic             stall
);
  logic hit_a, hit_b;

  always_comb begin
    hit_a = (ex_load_dst == id_src_a);
    hit_b = (ex_load_dst == id_src_b);
    stall = ex_is_load && (hit_a || hit_b);
  end

  // R4: with no load in execute, the interlock stays quiet
  assert_no_stall_without_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_load |-> !stall);
endmodule

// File: rtl/hzu_branch.sv
module hzu_branch #(
  parameter int unsigned ADDR_W = hzu_pkg::ADDR_W,
  parameter int unsigned OPC_W  = hzu_pkg::OPC_W,
  parameter int unsigned IMM_W  = hzu_pkg::IMM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [IMM_W-1:0]  offset,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic [ADDR_W-1:0] val_a,
  input  logic [ADDR_W-1:0] val_b,
  input  logic              hold,
  output logic              redirect,
  output logic [ADDR_W-1:0] target
);
  localparam int unsigned EXT_W = ADDR_W - IMM_W - 2;

  logic is_br, operands_eq;
  logic [ADDR_W-1:0] disp;

  always_comb begin
    is_br       = (opcode == hzu_pkg::OPC_BR_EQ);
    operands_eq = (val_a == val_b);
    disp        = {{EXT_W{offset[IMM_W-1]}}, offset, 2'b00};
    target      = next_addr + disp;
    redirect    = is_br && operands_eq && !hold;
  end

  // R6: a redirect only ever comes from an equal-compare branch
  assert_redirect_needs_branch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (opcode == hzu_pkg::OPC_BR_EQ) && (val_a == val_b));
endmodule

// File: rtl/hzu_front.sv
module hzu_front #(
  parameter int unsigned ADDR_W   = hzu_pkg::ADDR_W,
  parameter int unsigned INSTR_W  = hzu_pkg::INSTR_W,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pc_en,
  input  logic               id_en,
  input  logic               flush,
  input  logic [ADDR_W-1:0]  jump_addr,
  input  logic [INSTR_W-1:0] fetch_instr,
  output logic [ADDR_W-1:0]  pc,
  output logic [INSTR_W-1:0] id_instr,
  output logic [ADDR_W-1:0]  id_pc4
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] seq_addr;

  always_comb seq_addr = pc + STEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= RESET_PC;
    end else if (pc_en) begin
      pc <= flush ? jump_addr : seq_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_instr <= '0;
      id_pc4   <= '0;
    end else if (id_en) begin
      id_instr <= flush ? '0 : fetch_instr;
      id_pc4   <= seq_addr;
    end
  end

  // R5: a frozen cycle leaves the fetch address untouched
  assert_pc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_en |=> $stable(pc));
  // R5: a frozen cycle leaves the fetch/decode register untouched
  assert_ifid_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !id_en |=> $stable(id_instr) && $stable(id_pc4));
  // R8: a squash writes a zero word into decode
  assert_flush_zeroes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && id_en) |=> (id_instr == '0));
  // R6: a redirect lands on the computed target
  assert_redirect_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && pc_en) |=> (pc == $past(jump_addr)));
  // R2: sequential flow advances by one word
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_en && !flush) |=> (pc == $past(pc) + STEP));
endmodule

// File: rtl/hzu_top.sv
module hzu_top #(
  parameter int unsigned ADDR_W  = hzu_pkg::ADDR_W,
  parameter int unsigned INSTR_W = hzu_pkg::INSTR_W,
  parameter int unsigned REG_W   = hzu_pkg::REG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] fetch_instr,
  input  logic [ADDR_W-1:0]  rs_val,
  input  logic [ADDR_W-1:0]  rt_val,
  input  logic               ex_is_load,
  input  logic [REG_W-1:0]   ex_load_dst,
  output logic [ADDR_W-1:0]  pc,
  output logic [INSTR_W-1:0] id_instr,
  output logic [ADDR_W-1:0]  id_pc4,
  output logic               pc_en,
  output logic               id_en,
  output logic               bubble,
  output logic               if_flush,
  output logic [ADDR_W-1:0]  br_target
);
  localparam int unsigned OPC_W = hzu_pkg::OPC_W;
  localparam int unsigned IMM_W = hzu_pkg::IMM_W;

  logic stall, redirect;

  hzu_loaduse #(.REG_W(REG_W)) u_lu (
    .clk(clk), .rst_n(rst_n),
    .ex_is_load(ex_is_load), .ex_load_dst(ex_load_dst),
    .id_src_a(id_instr[hzu_pkg::SRC_A_LSB +: REG_W]),
    .id_src_b(id_instr[hzu_pkg::SRC_B_LSB +: REG_W]),
    .stall(stall)
  );

  hzu_branch #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .IMM_W(IMM_W)) u_br (
    .clk(clk), .rst_n(rst_n),
    .opcode(id_instr[hzu_pkg::OPC_LSB +: OPC_W]),
    .offset(id_instr[IMM_W-1:0]),
    .next_addr(id_pc4),
    .val_a(rs_val), .val_b(rt_val),
    .hold(stall),
    .redirect(redirect), .target(br_target)
  );

  always_comb begin
    bubble   = stall;
    pc_en    = !stall;
    id_en    = !stall;
    if_flush = redirect;
  end

  hzu_front #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_fe (
    .clk(clk), .rst_n(rst_n),
    .pc_en(pc_en), .id_en(id_en), .flush(if_flush),
    .jump_addr(br_target), .fetch_instr(fetch_instr),
    .pc(pc), .id_instr(id_instr), .id_pc4(id_pc4)
  );

  // R10: the interlock always beats a redirect
  assert_stall_beats_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !redirect);
endmodule

// File: tb/sim_hzu_top.sv
module sim_hzu_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fetch_instr, rs_val, rt_val;
  logic        ex_is_load;
  logic [4:0]  ex_load_dst;
  logic [31:0] pc, id_instr, id_pc4, br_target;
  logic        pc_en, id_en, bubble, if_flush;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  hzu_top u0 (
    .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr),
    .rs_val(rs_val), .rt_val(rt_val), .ex_is_load(ex_is_load),
    .ex_load_dst(ex_load_dst), .pc(pc), .id_instr(id_instr),
    .id_pc4(id_pc4), .pc_en(pc_en), .id_en(id_en), .bubble(bubble),
    .if_flush(if_flush), .br_target(br_target)
  );

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] a,
                                     input logic [4:0] b, input logic [15:0] imm);
    return {op, a, b, imm};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // advance one edge, then settle away from it
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic quiet();
    ex_is_load = 1'b0; ex_load_dst = 5'd0; rs_val = 32'd1; rt_val = 32'd2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; quiet(); fetch_instr = 32'h0;
    #22;
    chk("R1 pc", pc, 32'h0);
    chk("R1 id_instr", id_instr, 32'h0);
    chk("R1 id_pc4", id_pc4, 32'h0);
    @(negedge clk); rst_n = 1'b1; #1;
  endtask

  task automatic t_flow();
    logic [31:0] p0;
    logic [31:0] ia = mk(6'h00, 5'd1, 5'd2, 16'h1820);
    quiet(); fetch_instr = ia; #1;
    p0 = pc;
    chk("R2 pc_en", {31'd0, pc_en}, 32'd1);
    step();
    chk("R2 pc", pc, p0 + 4);
    chk("R2 id_instr", id_instr, ia);
    chk("R2 id_pc4", id_pc4, p0 + 4);
  endtask

  task automatic t_stall();
    logic [31:0] p0, ins;
    ins = mk(6'h00, 5'd3, 5'd4, 16'h2820);
    quiet(); fetch_instr = ins; step();
    fetch_instr = 32'hDEAD_BEEF;
    ex_is_load = 1'b1; ex_load_dst = 5'd4; #1;
    p0 = pc;
    chk("R3 bubble on src_b", {31'd0, bubble}, 32'd1);
    chk("R5 pc_en low", {31'd0, pc_en}, 32'd0);
    chk("R5 id_en low", {31'd0, id_en}, 32'd0);
    step();
    chk("R5 pc held", pc, p0);
    chk("R5 id_instr held", id_instr, ins);
    ex_load_dst = 5'd3; #1;
    chk("R3 bubble on src_a", {31'd0, bubble}, 32'd1);
    ex_is_load = 1'b0; #1;
    chk("R4 no load no bubble", {31'd0, bubble}, 32'd0);
    ex_is_load = 1'b1; ex_load_dst = 5'd7; #1;
    chk("R4 no match no bubble", {31'd0, bubble}, 32'd0);
    quiet();
    step();
    chk("R4 older load ignored", {31'd0, bubble}, 32'd0);
  endtask

  task automatic t_taken(input logic [15:0] off, input logic [31:0] disp, input string tag);
    logic [31:0] q;
    quiet(); fetch_instr = mk(6'h04, 5'd1, 5'd2, off); step();
    fetch_instr = 32'h1234_5678;
    rs_val = 32'd55; rt_val = 32'd55; #1;
    q = id_pc4;
    chk({tag, " R7 target"}, br_target, q + disp);
    chk({tag, " R6 flush"}, {31'd0, if_flush}, 32'd1);
    step();
    chk({tag, " R6 pc"}, pc, q + disp);
    chk({tag, " R8 squashed"}, id_instr, 32'h0);
    quiet();
  endtask

  task automatic t_not_taken();
    logic [31:0] p0;
    quiet(); fetch_instr = mk(6'h04, 5'd1, 5'd2, 16'd5); step();
    fetch_instr = 32'hCAFE_0001; rs_val = 32'd9; rt_val = 32'd8; #1;
    p0 = pc;
    chk("R9 no flush", {31'd0, if_flush}, 32'd0);
    step();
    chk("R9 pc", pc, p0 + 4);
    chk("R9 id_instr", id_instr, 32'hCAFE_0001);
    fetch_instr = mk(6'h08, 5'd1, 5'd2, 16'd5); step();
    rs_val = 32'd4; rt_val = 32'd4; #1;
    chk("R6 other opcode no flush", {31'd0, if_flush}, 32'd0);
    quiet();
  endtask

  task automatic t_collide();
    logic [31:0] p0, q, br;
    br = mk(6'h04, 5'd1, 5'd2, 16'd2);
    quiet(); fetch_instr = br; step();
    fetch_instr = 32'h7777_0000;
    rs_val = 32'd3; rt_val = 32'd3; ex_is_load = 1'b1; ex_load_dst = 5'd2; #1;
    p0 = pc; q = id_pc4;
    chk("R10 bubble", {31'd0, bubble}, 32'd1);
    chk("R10 no flush", {31'd0, if_flush}, 32'd0);
    step();
    chk("R10 pc held", pc, p0);
    chk("R10 branch held", id_instr, br);
    ex_is_load = 1'b0; #1;
    chk("R10 flush next", {31'd0, if_flush}, 32'd1);
    step();
    chk("R10 redirect", pc, q + 8);
    chk("R10 squashed", id_instr, 32'h0);
    quiet();
  endtask

  initial begin
    #150000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_flow();
    t_flow();
    t_stall();
    t_taken(16'd3, 32'd12, "fwd");
    t_taken(16'hFFFE, 32'hFFFF_FFF8, "back");
    t_not_taken();
    t_collide();
    t_flow();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule